// File: doc/BRIEF.md
# Page Table Walker with Translation Buffer

This block sits between a CPU and main memory and binds each logical address to a physical address. The logical address is split into a page number (upper bits) and a displacement (lower `OFF_W` bits). The page table lives in main memory as a contiguous array of frame numbers. A context base register gives the memory address of entry 0, and a context limit register gives the highest legal page number. Both registers are per-process state and are written on a context switch.

A small fully associative translation buffer holds recently used page/frame pairs. Each request follows one of three paths:
- **Out of range.** A page number above the limit register returns a trap response. No memory traffic is issued.
- **Buffer hit.** The frame comes straight from the buffer, and the response is presented one cycle after the request is accepted.
- **Buffer miss.** One page table read is issued at base + page. The returned frame is joined with the displacement, and the new pair is installed in the buffer.

The CPU request, CPU response and memory read request are valid/ready streams. A transfer happens on a rising edge where both valid and ready are high. Once valid is raised, the sender holds valid and its payload stable until that transfer occurs. The block accepts one request at a time: `req_ready` is low from acceptance until the response is taken, so a stalled `rsp_ready` back-pressures the CPU request side. The memory read response is a plain valid pulse. It is accepted only while a read is outstanding.

Top module: `ptw_top`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the buffer is empty, so the first request for any page costs one memory read.
- R2: A request whose page number is greater than the limit register gets a response with `rsp_fault`=1 and `rsp_paddr`=0, and issues no memory read. A page number equal to the limit is legal.
- R3: On a buffer miss, exactly one memory read is issued at address base + page number (modulo 2^MA_W). The response carries `rsp_fault`=0 and `rsp_paddr` = {returned frame, displacement}, with the frame in the upper FN_W bits.
- R4: On a buffer hit, `rsp_valid` is high in the cycle right after the request handshake, with no memory read.
- R5: A frame fetched on a miss is installed, so a later request for the same page hits. No page is held in two entries.
- R6: Empty entries fill from index 0 upward. When all entries are valid, a miss replaces them in round-robin order starting at entry 0.
- R7: A pulse on `flush` invalidates every buffer entry.
- R8: Writing the base register also invalidates the buffer, and later walks use the new base.
- R9: A limit write applies to the next request, and the limit check comes before the buffer, so a cached page above the new limit traps.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response and its payload hold stable and `req_ready` stays low.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the read request and its address hold stable.
- R12: A flush or base write that arrives while a walk is outstanding still lets that walk respond correctly, but its frame is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | VA_W | Logical address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | CPU takes the response |
| rsp_paddr | output | FN_W+OFF_W | Physical address (0 on trap) |
| rsp_fault | output | 1 | Page number above limit |
| mem_req_valid | output | 1 | Page table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | MA_W | Address of the page table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | FN_W | Frame number read |
| base_we | input | 1 | Write the base register (flushes the buffer) |
| base_wdata | input | MA_W | New page table base |
| limit_we | input | 1 | Write the limit register |
| limit_wdata | input | VA_W-OFF_W | New highest legal page number |
| flush | input | 1 | Invalidate all buffer entries |

## Verification
The bench builds the block with its defaults: a 16-bit logical address with an 8-bit displacement, 8-bit frames, a 16-bit memory address and four buffer entries. Four entries are filled by the fourth distinct page, so fill order, round-robin eviction and wrap of the replacement pointer all appear in a short request sequence. The 8-bit page field makes a trap above a mid-range limit, and a hit on a page at exactly the limit, easy to reach. A memory model with adjustable ready delay and read latency drives walks that stall, and leaves time to flush the buffer in the middle of a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_MREQ  = 2'd1,
    WK_MWAIT = 2'd2,
    WK_RESP  = 2'd3
  } walk_st_e;
endpackage

// File: rtl/ptw_tlb.sv
module ptw_tlb #(
  parameter int PN_W    = 8,
  parameter int FN_W    = 8,
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inval,
  input  logic [PN_W-1:0]    lk_page,
  output logic               lk_hit,
  output logic [FN_W-1:0]    lk_frame,
  input  logic               ins_en,
  input  logic [PN_W-1:0]    ins_page,
  input  logic [FN_W-1:0]    ins_frame,
  output logic [ENTRIES-1:0] ent_vld,
  output logic [ENTRIES-1:0] hit_vec
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [PN_W-1:0]  page_q  [ENTRIES];
  logic [FN_W-1:0]  frame_q [ENTRIES];
  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] slot;
  logic             any_free;

  // one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = ent_vld[g] && (page_q[g] == lk_page);
  end

  assign lk_hit = |hit_vec;

  always_comb begin
    lk_frame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) lk_frame = lk_frame | frame_q[i];
    end
  end

  // lowest empty entry, if any
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_vld[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign slot = any_free ? free_idx : rr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld <= '0;
      rr_ptr  <= '0;
    end else if (inval) begin
      ent_vld <= '0;
      rr_ptr  <= '0;
    end else if (ins_en) begin
      ent_vld[slot] <= 1'b1;
      if (!any_free) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en && !inval) begin
      page_q[slot]  <= ins_page;
      frame_q[slot] <= ins_frame;
    end
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int VA_W  = 16,
  parameter int OFF_W = 8,
  parameter int FN_W  = 8,
  parameter int MA_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_laddr,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [FN_W+OFF_W-1:0] rsp_paddr,
  output logic                  rsp_fault,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [MA_W-1:0]       mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [FN_W-1:0]       mem_rsp_data,
  input  logic [MA_W-1:0]       base,
  input  logic [VA_W-OFF_W-1:0] limit,
  input  logic                  inval,
  output logic [VA_W-OFF_W-1:0] lk_page,
  input  logic                  lk_hit,
  input  logic [FN_W-1:0]       lk_frame,
  output logic                  ins_en,
  output logic [VA_W-OFF_W-1:0] ins_page,
  output logic [FN_W-1:0]       ins_frame
);
  localparam int PN_W = VA_W - OFF_W;
  localparam int PA_W = FN_W + OFF_W;

  walk_st_e          st_q;
  logic [PN_W-1:0]   page_q;
  logic [OFF_W-1:0]  off_q;
  logic [MA_W-1:0]   addr_q;
  logic              stale_q;
  logic [PA_W-1:0]   paddr_q;
  logic              fault_q;
  logic [OFF_W-1:0]  req_off;

  assign lk_page = req_laddr[VA_W-1:OFF_W];
  assign req_off = req_laddr[OFF_W-1:0];

  assign req_ready     = (st_q == WK_IDLE);
  assign rsp_valid     = (st_q == WK_RESP);
  assign mem_req_valid = (st_q == WK_MREQ);
  assign mem_req_addr  = addr_q;
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;

  assign ins_en    = (st_q == WK_MWAIT) && mem_rsp_valid && !stale_q && !inval;
  assign ins_page  = page_q;
  assign ins_frame = mem_rsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WK_IDLE;
      page_q  <= '0;
      off_q   <= '0;
      addr_q  <= '0;
      stale_q <= 1'b0;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else begin
      case (st_q)
        WK_IDLE: begin
          if (req_valid) begin
            page_q <= lk_page;
            off_q  <= req_off;
            if (lk_page > limit) begin
              fault_q <= 1'b1;
              paddr_q <= '0;
              st_q    <= WK_RESP;
            end else if (lk_hit) begin
              fault_q <= 1'b0;
              paddr_q <= {lk_frame, req_off};
              st_q    <= WK_RESP;
            end else begin
              addr_q  <= base + MA_W'(lk_page);
              stale_q <= 1'b0;
              st_q    <= WK_MREQ;
            end
          end
        end
        WK_MREQ: begin
          if (inval) stale_q <= 1'b1;
          if (mem_req_ready) st_q <= WK_MWAIT;
        end
        WK_MWAIT: begin
          if (inval) stale_q <= 1'b1;
          if (mem_rsp_valid) begin
            fault_q <= 1'b0;
            paddr_q <= {mem_rsp_data, off_q};
            st_q    <= WK_RESP;
          end
        end
        WK_RESP: begin
          if (rsp_ready) st_q <= WK_IDLE;
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_top.sv
module ptw_top #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 8,
  parameter int FN_W  = 8,
  parameter int MA_W  = 16,
  parameter int TLB_N = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_laddr,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [FN_W+OFF_W-1:0] rsp_paddr,
  output logic                  rsp_fault,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [MA_W-1:0]       mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [FN_W-1:0]       mem_rsp_data,
  input  logic                  base_we,
  input  logic [MA_W-1:0]       base_wdata,
  input  logic                  limit_we,
  input  logic [VA_W-OFF_W-1:0] limit_wdata,
  input  logic                  flush
);
  localparam int PN_W = VA_W - OFF_W;

  logic [MA_W-1:0]  base_q;
  logic [PN_W-1:0]  limit_q;
  logic             inval;
  logic [PN_W-1:0]  lk_page;
  logic             lk_hit;
  logic [FN_W-1:0]  lk_frame;
  logic             ins_en;
  logic [PN_W-1:0]  ins_page;
  logic [FN_W-1:0]  ins_frame;
  logic [TLB_N-1:0] tlb_vld;
  logic [TLB_N-1:0] hit_vec;

  assign inval = flush || base_we;

  // process context registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
    end else begin
      if (base_we)  base_q  <= base_wdata;
      if (limit_we) limit_q <= limit_wdata;
    end
  end

  ptw_ctrl #(.VA_W(VA_W), .OFF_W(OFF_W), .FN_W(FN_W), .MA_W(MA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .base(base_q), .limit(limit_q), .inval(inval),
    .lk_page(lk_page), .lk_hit(lk_hit), .lk_frame(lk_frame),
    .ins_en(ins_en), .ins_page(ins_page), .ins_frame(ins_frame)
  );

  ptw_tlb #(.PN_W(PN_W), .FN_W(FN_W), .ENTRIES(TLB_N)) tlb_i (
    .clk(clk), .rst_n(rst_n), .inval(inval),
    .lk_page(lk_page), .lk_hit(lk_hit), .lk_frame(lk_frame),
    .ins_en(ins_en), .ins_page(ins_page), .ins_frame(ins_frame),
    .ent_vld(tlb_vld), .hit_vec(hit_vec)
  );
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
  parameter int PA_W = 16,
  parameter int MA_W = 16,
  parameter int N    = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_fault,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [MA_W-1:0] mem_req_addr,
  input logic            flush,
  input logic            base_we,
  input logic [N-1:0]    tlb_vld,
  input logic [N-1:0]    hit_vec
);
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R2
  trap_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);

  // R3
  walk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready && !rsp_valid);

  // R5
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R5
  no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && !base_we |=> $countones(tlb_vld) >= $countones($past(tlb_vld)));

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> tlb_vld == '0);

  // R8
  base_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> tlb_vld == '0);
endmodule

bind ptw_top ptw_chk #(.PA_W(FN_W + OFF_W), .MA_W(MA_W), .N(TLB_N)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .flush(flush), .base_we(base_we),
  .tlb_vld(tlb_vld), .hit_vec(hit_vec)
);

// File: tb/ptw_top_tb_top.sv
`timescale 1ns/1ps
module ptw_top_tb_top;
  localparam int VA_W = 16, OFF_W = 8, FN_W = 8, MA_W = 16, TLB_N = 4;
  localparam int PN_W = VA_W - OFF_W;
  localparam int PA_W = FN_W + OFF_W;

  // vector: {logical address, expect trap, expected memory reads}
  localparam int NV = 14;
  localparam logic [18:0] VEC [NV] = '{
    {16'h0312, 1'b0, 2'd1},  // R3 cold miss
    {16'h0377, 1'b0, 2'd0},  // R4 / R5 hit
    {16'h2501, 1'b1, 2'd0},  // R2 above limit
    {16'h2000, 1'b0, 2'd1},  // R2 page equals limit
    {16'h0400, 1'b0, 2'd1},
    {16'h0500, 1'b0, 2'd1},  // buffer now full
    {16'h06AA, 1'b0, 2'd1},  // R6 evicts entry 0 (page 03)
    {16'h0301, 1'b0, 2'd1},  // R6 evicts entry 1 (page 20)
    {16'h0444, 1'b0, 2'd0},
    {16'h0555, 1'b0, 2'd0},
    {16'h06FF, 1'b0, 2'd0},
    {16'h2010, 1'b0, 2'd1},  // R6 evicts entry 2
    {16'h0000, 1'b0, 2'd1},  // R6 evicts entry 3, pointer wraps
    {16'h2100, 1'b1, 2'd0}   // R2
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [VA_W-1:0] req_laddr = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [PA_W-1:0] rsp_paddr;
  logic rsp_fault;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [MA_W-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [FN_W-1:0] mem_rsp_data = '0;
  logic base_we = 1'b0;
  logic [MA_W-1:0] base_wdata = '0;
  logic limit_we = 1'b0;
  logic [PN_W-1:0] limit_wdata = '0;
  logic flush = 1'b0;

  int n_chk = 0, n_bad = 0, reads = 0, mem_gap = 0;
  logic [MA_W-1:0] last_addr = '0;
  logic [MA_W-1:0] cur_base = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ptw_top #(.VA_W(VA_W), .OFF_W(OFF_W), .FN_W(FN_W), .MA_W(MA_W), .TLB_N(TLB_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_laddr(req_laddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .base_we(base_we), .base_wdata(base_wdata),
    .limit_we(limit_we), .limit_wdata(limit_wdata), .flush(flush)
  );

  function automatic logic [FN_W-1:0] frame_of(input logic [MA_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [PA_W-1:0] exp_pa(input logic [VA_W-1:0] la);
    return {frame_of(cur_base + MA_W'(la[VA_W-1:OFF_W])), la[OFF_W-1:0]};
  endfunction

  task automatic check(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // page table memory model
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        last_addr = mem_req_addr;
        repeat (mem_gap) @(negedge clk);
        if (mem_gap > 0)
          check(mem_req_valid && mem_req_addr == last_addr,
                $sformatf("R11 held addr act=%h exp=%h", mem_req_addr, last_addr));
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        reads++;
        repeat (2) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = frame_of(last_addr);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic do_req(input logic [VA_W-1:0] la, output logic flt,
                        output logic [PA_W-1:0] pa, output int lat, output int nrd);
    int r0;
    r0 = reads;
    @(negedge clk);
    req_valid = 1'b1;
    req_laddr = la;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    flt = rsp_fault;
    pa  = rsp_paddr;
    @(negedge clk);
    nrd = reads - r0;
  endtask

  task automatic run_chk(input logic [VA_W-1:0] la, input logic eflt,
                         input int erd, input string tag);
    logic flt;
    logic [PA_W-1:0] pa, epa;
    int lat, nrd;
    do_req(la, flt, pa, lat, nrd);
    epa = eflt ? '0 : exp_pa(la);
    check(flt == eflt, $sformatf("%s la=%h fault act=%0b exp=%0b", tag, la, flt, eflt));
    check(pa == epa, $sformatf("%s la=%h paddr act=%h exp=%h", tag, la, pa, epa));
    check(nrd == erd, $sformatf("%s la=%h reads act=%0d exp=%0d", tag, la, nrd, erd));
    if (erd == 0 && !eflt)
      check(lat == 1, $sformatf("R4 la=%h latency act=%0d exp=1", la, lat));
  endtask

  task automatic set_ctx(input logic [MA_W-1:0] b, input logic [PN_W-1:0] l, input bit wb);
    @(negedge clk);
    if (wb) begin
      base_we = 1'b1;
      base_wdata = b;
      cur_base = b;
    end
    limit_we = 1'b1;
    limit_wdata = l;
    @(negedge clk);
    base_we = 1'b0;
    limit_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=expired exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(req_ready == 1'b1, $sformatf("R1 req_ready act=%0b exp=1", req_ready));
    check(rsp_valid == 1'b0, $sformatf("R1 rsp_valid act=%0b exp=0", rsp_valid));
    check(mem_req_valid == 1'b0, $sformatf("R1 mem_req_valid act=%0b exp=0", mem_req_valid));
    run_chk(16'h0000, 1'b0, 1, "R1");  // limit 0 after reset, cold buffer

    set_ctx(16'h1000, 8'h20, 1'b1);
    for (int i = 0; i < NV; i++) begin
      run_chk(VEC[i][18:3], VEC[i][2], int'(VEC[i][1:0]), "R2/R3/R4/R5/R6 vec");
      if (i == 0)
        check(last_addr == 16'h1003, $sformatf("R3 walk addr act=%h exp=1003", last_addr));
    end

    // R7: flush drops cached page 03
    run_chk(16'h0310, 1'b0, 0, "R7 before");
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    run_chk(16'h0310, 1'b0, 1, "R7 after");

    // R8: base write flushes and relocates walks
    set_ctx(16'h2200, 8'h20, 1'b1);
    run_chk(16'h0312, 1'b0, 1, "R8");
    check(last_addr == 16'h2203, $sformatf("R8 walk addr act=%h exp=2203", last_addr));
    run_chk(16'h0312, 1'b0, 0, "R8 rehit");

    // R9: lowered limit traps cached page
    set_ctx(16'h0, 8'h02, 1'b0);
    run_chk(16'h0312, 1'b1, 0, "R9");
    run_chk(16'h0201, 1'b0, 1, "R9 at limit");
    set_ctx(16'h0, 8'h20, 1'b0);

    // R10: response back-pressure
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_laddr = 16'h0233;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(rsp_valid && !req_ready && rsp_paddr == exp_pa(16'h0233),
            $sformatf("R10 hold v=%0b rdy=%0b pa act=%h exp=%h",
                      rsp_valid, req_ready, rsp_paddr, exp_pa(16'h0233)));
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check(!rsp_valid && req_ready, $sformatf("R10 release v=%0b act exp=0", rsp_valid));

    // R11: stalled memory request
    mem_gap = 3;
    run_chk(16'h0707, 1'b0, 1, "R11");

    // R12: flush in the middle of a walk
    fork
      run_chk(16'h0808, 1'b0, 1, "R12 walk");
      begin
        wait (mem_req_valid);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
      end
    join
    mem_gap = 0;
    run_chk(16'h0808, 1'b0, 1, "R12 not installed");
    run_chk(16'h0808, 1'b0, 0, "R12 installed later");

    finish_run();
  end
endmodule